// File: doc/BRIEF.md
# Rename Register Occupancy Tracker

This block counts, for each of several physical register pools in an out-of-order core, how many rename entries are currently held. Every architectural register carries a membership mask with one bit per pool; a register may belong to several pools at once. When a destination register is renamed, the block adds one entry to every pool in its mask. When the instruction retires, the block removes one entry from every pool in its mask. The block also keeps, for each pool, the highest occupancy seen and the number of allocations made.

Before dispatch, the front end puts up to `QN` destination register IDs on a combinational query port. The block adds up how many new entries each pool would need. It returns a stall mask that holds one bit per pool that lacks room. An all-zero stall mask means that every pool can take the group. A pool with capacity zero has no limit and never stalls. A separate flag per pool reports a group that could never fit, because it asks for more entries than the pool holds in total. Membership masks and capacities are loaded through a small configuration port.

The allocate and release inputs are single-cycle valid strobes. There is no ready signal: both are accepted on every clock, so the block never applies back-pressure. The caller must hold back an allocate while the query reports a stall.

Top module: `rfm_tracker`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every occupancy, peak and allocation counter, all membership masks and all capacities to zero.
- R2: A configuration write (`cfg_valid` high) acts according to `cfg_op`. Code 0 writes the mask of register `cfg_idx` from `cfg_data[NF-1:0]`. Code 1 writes the capacity of pool `cfg_idx` from `cfg_data[CW-1:0]`. Code 2 sets bit `cfg_idx` in the mask of every register. Code 3 changes nothing.
- R3: An allocate of register r increments, at the next edge, the occupancy of every pool whose bit is set in r's mask. Other pools keep their occupancy.
- R4: A release of register r decrements, at the next edge, the occupancy of every pool whose bit is set in r's mask.
- R5: When an allocate and a release reach the same pool in the same cycle, that pool's occupancy does not change.
- R6: When a release alone reaches a pool whose occupancy is zero, the occupancy stays zero and the pool's bit in `rel_err` is high for the following cycle.
- R7: Each pool's peak counter equals the largest occupancy that pool has held since reset.
- R8: Each pool's allocation counter increases by one for every allocate whose mask includes that pool.
- R9: For pool i, `q_stall[i]` is high, within the same cycle, when capacity_i is nonzero and capacity_i < occupancy_i + need_i. need_i is the number of enabled query slots whose register belongs to pool i. Bit 0 of each field is pool 0, and slot s uses `q_id[s*AW +: AW]`.
- R10: A pool with capacity zero never raises `q_stall` or `q_too_big`.
- R11: `q_too_big[i]` is high when capacity_i is nonzero and need_i exceeds capacity_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | Configuration operation code (R2) |
| cfg_idx | input | IW | Register or pool index for the write |
| cfg_data | input | DW | Mask or capacity value |
| alloc_valid | input | 1 | Allocate strobe |
| alloc_id | input | AW | Register being allocated |
| rel_valid | input | 1 | Release strobe |
| rel_id | input | AW | Register being released |
| q_en | input | QN | Query slot enables |
| q_id | input | QN*AW | Query slot register IDs |
| q_stall | output | NF | Pools without room for the query |
| q_too_big | output | NF | Pools whose total capacity is below the query's need |
| rel_err | output | NF | Release at zero occupancy, one cycle per pool |
| use_cnt | output | NF*CW | Occupancy per pool |
| peak_cnt | output | NF*CW | Peak occupancy per pool |
| total_cnt | output | NF*TW | Allocations per pool |

## Verification
The assertions assume two things about the inputs. No pool's occupancy is driven past its counter width. Between resets, the allocation counters never wrap. The stimulus biases releases above allocates, so occupancy stays near the small capacities. It also runs far fewer cycles than would wrap a TW-bit counter. Releases at zero and same-cycle allocate/release pairs are legal input, so the stimulus includes them on purpose rather than avoiding them.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
  typedef enum logic [1:0] {
    CFG_MASK = 2'd0,
    CFG_CAP  = 2'd1,
    CFG_JOIN = 2'd2,
    CFG_NOP  = 2'd3
  } cfg_op_e;
endpackage

// File: rtl/rfm_cfg_store.sv
module rfm_cfg_store #(
  parameter int NF = 4,
  parameter int NA = 16,
  parameter int CW = 6,
  parameter int IW = 4,
  parameter int DW = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_valid,
  input  logic [1:0]       cfg_op,
  input  logic [IW-1:0]    cfg_idx,
  input  logic [DW-1:0]    cfg_data,
  output logic [NA*NF-1:0] mask_flat,
  output logic [NF*CW-1:0] cap_flat
);
  import rfm_pkg::*;
  cfg_op_e op;
  assign op = cfg_op_e'(cfg_op);

  logic [NF-1:0] mask_q [NA];
  logic [CW-1:0] cap_q  [NF];

  for (genvar r = 0; r < NA; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[r] <= '0;
      end else if (cfg_valid) begin
        if (op == CFG_MASK && cfg_idx == IW'(r)) begin
          mask_q[r] <= cfg_data[NF-1:0];
        end else if (op == CFG_JOIN) begin
          for (int f = 0; f < NF; f++) begin
            if (cfg_idx == IW'(f)) mask_q[r][f] <= 1'b1;
          end
        end
      end
    end
    assign mask_flat[r*NF +: NF] = mask_q[r];
  end

  for (genvar f = 0; f < NF; f++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst) begin
        cap_q[f] <= '0;
      end else if (cfg_valid && op == CFG_CAP && cfg_idx == IW'(f)) begin
        cap_q[f] <= cfg_data[CW-1:0];
      end
    end
    assign cap_flat[f*CW +: CW] = cap_q[f];
  end
endmodule

// File: rtl/rfm_file_ctr.sv
module rfm_file_ctr #(
  parameter int CW = 6,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] use_q,
  output logic [CW-1:0] peak_q,
  output logic [TW-1:0] total_q,
  output logic          err_q
);
  logic [CW-1:0] nxt;
  logic          uf;

  always_comb begin
    nxt = use_q;
    uf  = 1'b0;
    if (inc && !dec) begin
      nxt = use_q + 1'b1;
    end else if (dec && !inc) begin
      if (use_q == '0) uf  = 1'b1;
      else             nxt = use_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      use_q   <= '0;
      peak_q  <= '0;
      total_q <= '0;
      err_q   <= 1'b0;
    end else begin
      use_q   <= nxt;
      if (nxt > peak_q) peak_q <= nxt;
      total_q <= total_q + TW'(inc);
      err_q   <= uf;
    end
  end
endmodule

// File: rtl/rfm_need_calc.sv
module rfm_need_calc #(
  parameter int NF = 4,
  parameter int NA = 16,
  parameter int AW = 4,
  parameter int QN = 3,
  parameter int CW = 6
) (
  input  logic [NA*NF-1:0] mask_flat,
  input  logic [NF*CW-1:0] cap_flat,
  input  logic [NF*CW-1:0] use_flat,
  input  logic [QN-1:0]    q_en,
  input  logic [QN*AW-1:0] q_id,
  output logic [NF-1:0]    q_stall,
  output logic [NF-1:0]    q_too_big
);
  localparam int NW = $clog2(QN + 1);
  localparam int EW = CW + NW + 1;

  logic [NF-1:0] m [NA];
  for (genvar r = 0; r < NA; r++) begin : g_unpack
    assign m[r] = mask_flat[r*NF +: NF];
  end

  logic [NF-1:0] slot_m [QN];
  for (genvar s = 0; s < QN; s++) begin : g_slot
    assign slot_m[s] = q_en[s] ? m[q_id[s*AW +: AW]] : '0;
  end

  logic [NW-1:0] need [NF];
  always_comb begin
    for (int f = 0; f < NF; f++) begin
      need[f] = '0;
      for (int s = 0; s < QN; s++) begin
        need[f] = need[f] + NW'(slot_m[s][f]);
      end
    end
  end

  for (genvar f = 0; f < NF; f++) begin : g_cmp
    logic [EW-1:0] cap_e, sum_e;
    logic          bounded;
    assign cap_e        = EW'(cap_flat[f*CW +: CW]);
    assign sum_e        = EW'(use_flat[f*CW +: CW]) + EW'(need[f]);
    assign bounded      = (cap_flat[f*CW +: CW] != '0);
    assign q_stall[f]   = bounded && (cap_e < sum_e);
    assign q_too_big[f] = bounded && (EW'(need[f]) > cap_e);
  end
endmodule

// File: rtl/rfm_tracker.sv
module rfm_tracker #(
  parameter int NF = 4,
  parameter int NA = 16,
  parameter int CW = 6,
  parameter int TW = 16,
  parameter int QN = 3,
  localparam int AW = $clog2(NA),
  localparam int FW = (NF > 1) ? $clog2(NF) : 1,
  localparam int IW = (AW > FW) ? AW : FW,
  localparam int DW = (NF > CW) ? NF : CW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_valid,
  input  logic [1:0]       cfg_op,
  input  logic [IW-1:0]    cfg_idx,
  input  logic [DW-1:0]    cfg_data,
  input  logic             alloc_valid,
  input  logic [AW-1:0]    alloc_id,
  input  logic             rel_valid,
  input  logic [AW-1:0]    rel_id,
  input  logic [QN-1:0]    q_en,
  input  logic [QN*AW-1:0] q_id,
  output logic [NF-1:0]    q_stall,
  output logic [NF-1:0]    q_too_big,
  output logic [NF-1:0]    rel_err,
  output logic [NF*CW-1:0] use_cnt,
  output logic [NF*CW-1:0] peak_cnt,
  output logic [NF*TW-1:0] total_cnt
);
  logic [NA*NF-1:0] mask_flat;
  logic [NF*CW-1:0] cap_flat;

  rfm_cfg_store #(.NF(NF), .NA(NA), .CW(CW), .IW(IW), .DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_op(cfg_op),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .mask_flat(mask_flat), .cap_flat(cap_flat)
  );

  logic [NF-1:0] m [NA];
  for (genvar r = 0; r < NA; r++) begin : g_unpack
    assign m[r] = mask_flat[r*NF +: NF];
  end

  logic [NF-1:0] a_hit, r_hit;
  assign a_hit = alloc_valid ? m[alloc_id] : '0;
  assign r_hit = rel_valid   ? m[rel_id]   : '0;

  for (genvar f = 0; f < NF; f++) begin : g_file
    rfm_file_ctr #(.CW(CW), .TW(TW)) u_ctr (
      .clk(clk), .rst(rst), .inc(a_hit[f]), .dec(r_hit[f]),
      .use_q(use_cnt[f*CW +: CW]), .peak_q(peak_cnt[f*CW +: CW]),
      .total_q(total_cnt[f*TW +: TW]), .err_q(rel_err[f])
    );
  end

  rfm_need_calc #(.NF(NF), .NA(NA), .AW(AW), .QN(QN), .CW(CW)) u_need (
    .mask_flat(mask_flat), .cap_flat(cap_flat), .use_flat(use_cnt),
    .q_en(q_en), .q_id(q_id), .q_stall(q_stall), .q_too_big(q_too_big)
  );
endmodule

// File: rtl/rfm_tracker_chk.sv
module rfm_tracker_chk #(
  parameter int NF = 4,
  parameter int CW = 6,
  parameter int TW = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_valid,
  input logic             rel_valid,
  input logic [NF-1:0]    q_stall,
  input logic [NF-1:0]    q_too_big,
  input logic [NF-1:0]    rel_err,
  input logic [NF*CW-1:0] use_cnt,
  input logic [NF*CW-1:0] peak_cnt,
  input logic [NF*TW-1:0] total_cnt,
  input logic [NF*CW-1:0] cap_flat
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  for (genvar f = 0; f < NF; f++) begin : g_f
    p_peak_bound_r7: assert property (@(posedge clk) disable iff (rst)
      peak_cnt[f*CW +: CW] >= use_cnt[f*CW +: CW]);

    p_step_r5: assert property (@(posedge clk) disable iff (rst)
      past_ok |-> (use_cnt[f*CW +: CW] == $past(use_cnt[f*CW +: CW]))
               || (use_cnt[f*CW +: CW] == $past(use_cnt[f*CW +: CW]) + 1'b1)
               || (use_cnt[f*CW +: CW] == $past(use_cnt[f*CW +: CW]) - 1'b1));

    p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !alloc_valid && !rel_valid) |=> $stable(use_cnt[f*CW +: CW]));

    p_total_step_r8: assert property (@(posedge clk) disable iff (rst)
      past_ok |-> (total_cnt[f*TW +: TW] == $past(total_cnt[f*TW +: TW]))
               || (total_cnt[f*TW +: TW] == $past(total_cnt[f*TW +: TW]) + 1'b1));

    p_err_at_zero_r6: assert property (@(posedge clk) disable iff (rst)
      rel_err[f] |-> (use_cnt[f*CW +: CW] == '0));

    p_toobig_stalls_r11: assert property (@(posedge clk) disable iff (rst)
      q_too_big[f] |-> q_stall[f]);

    p_unbounded_r10: assert property (@(posedge clk) disable iff (rst)
      (cap_flat[f*CW +: CW] == '0) |-> !(q_stall[f] || q_too_big[f]));
  end
endmodule

bind rfm_tracker rfm_tracker_chk #(.NF(NF), .CW(CW), .TW(TW)) u_chk (
  .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .rel_valid(rel_valid),
  .q_stall(q_stall), .q_too_big(q_too_big), .rel_err(rel_err),
  .use_cnt(use_cnt), .peak_cnt(peak_cnt), .total_cnt(total_cnt),
  .cap_flat(cap_flat)
);

// File: tb/sim_rfm_tracker.sv
module sim_rfm_tracker;
  localparam int NF = 4, NA = 16, CW = 6, TW = 16, QN = 3, AW = 4, IW = 4, DW = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, cfg_valid, alloc_valid, rel_valid;
  logic [1:0] cfg_op;
  logic [IW-1:0] cfg_idx;
  logic [DW-1:0] cfg_data;
  logic [AW-1:0] alloc_id, rel_id;
  logic [QN-1:0] q_en;
  logic [QN*AW-1:0] q_id;
  logic [NF-1:0] q_stall, q_too_big, rel_err;
  logic [NF*CW-1:0] use_cnt, peak_cnt;
  logic [NF*TW-1:0] total_cnt;

  rfm_tracker u0 (.*);

  int n_chk = 0, n_fail = 0;
  int m_mask [NA];
  int m_cap [NF], m_use [NF], m_peak [NF], m_total [NF];
  logic [NF-1:0] m_err;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int need_of(int f, logic [QN-1:0] en, logic [QN*AW-1:0] ids);
    int n = 0;
    for (int s = 0; s < QN; s++)
      if (en[s] && m_mask[ids[s*AW +: AW]][f]) n++;
    return n;
  endfunction

  task automatic check_state(input string tag);
    for (int f = 0; f < NF; f++) begin
      chk(use_cnt[f*CW +: CW] == CW'(m_use[f]), {tag, " use"}, int'(use_cnt[f*CW +: CW]), m_use[f]);
      chk(peak_cnt[f*CW +: CW] == CW'(m_peak[f]), "R7 peak", int'(peak_cnt[f*CW +: CW]), m_peak[f]);
      chk(total_cnt[f*TW +: TW] == TW'(m_total[f]), "R8 total", int'(total_cnt[f*TW +: TW]), m_total[f]);
      chk(rel_err[f] == m_err[f], "R6 rel_err", int'(rel_err[f]), int'(m_err[f]));
    end
  endtask

  task automatic check_query();
    for (int f = 0; f < NF; f++) begin
      int nd = need_of(f, q_en, q_id);
      bit es = (m_cap[f] != 0) && (m_cap[f] < m_use[f] + nd);
      bit et = (m_cap[f] != 0) && (nd > m_cap[f]);
      chk(q_stall[f] == es, m_cap[f] == 0 ? "R10 stall" : "R9 stall", int'(q_stall[f]), int'(es));
      chk(q_too_big[f] == et, m_cap[f] == 0 ? "R10 too_big" : "R11 too_big", int'(q_too_big[f]), int'(et));
    end
  endtask

  // starts and ends at a negedge
  task automatic step(input bit av, input int aid, input bit rv, input int rid,
                      input logic [QN-1:0] en, input logic [QN*AW-1:0] ids, input string tag);
    alloc_valid = av; alloc_id = AW'(aid); rel_valid = rv; rel_id = AW'(rid);
    q_en = en; q_id = ids;
    #1 check_query();
    @(posedge clk);
    for (int f = 0; f < NF; f++) begin
      bit a = av && m_mask[aid][f];
      bit r = rv && m_mask[rid][f];
      m_err[f] = 1'b0;
      if (a && !r) m_use[f] = (m_use[f] + 1) % (1 << CW);
      else if (r && !a) begin
        if (m_use[f] == 0) m_err[f] = 1'b1;
        else m_use[f]--;
      end
      if (m_use[f] > m_peak[f]) m_peak[f] = m_use[f];
      if (a) m_total[f]++;
    end
    @(negedge clk);
    alloc_valid = 0; rel_valid = 0;
    #1 check_state(tag);
  endtask

  task automatic cfg(input int op, input int idx, input int data);
    cfg_valid = 1; cfg_op = 2'(op); cfg_idx = IW'(idx); cfg_data = DW'(data);
    @(posedge clk);
    case (op)
      0: m_mask[idx] = data & ((1 << NF) - 1);
      1: m_cap[idx] = data & ((1 << CW) - 1);
      2: for (int r = 0; r < NA; r++) m_mask[r] |= (1 << idx);
      default: ;
    endcase
    @(negedge clk);
    cfg_valid = 0;
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog act=%0d exp=%0d", n_chk, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(7);
    rst = 1; cfg_valid = 0; cfg_op = 0; cfg_idx = 0; cfg_data = 0;
    alloc_valid = 0; alloc_id = 0; rel_valid = 0; rel_id = 0; q_en = 0; q_id = 0;
    for (int r = 0; r < NA; r++) m_mask[r] = 0;
    for (int f = 0; f < NF; f++) begin m_cap[f] = 0; m_use[f] = 0; m_peak[f] = 0; m_total[f] = 0; end
    m_err = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    #1 check_state("R1 reset");

    // R2: masks, capacities, join-all, no-op
    for (int r = 0; r < NA; r++) cfg(0, r, int'($urandom_range(0, 7)));
    cfg(0, 5, 0);
    cfg(2, 3, 0);
    cfg(0, 9, 1);   // register 9 in pool 0 only
    cfg(1, 0, 2); cfg(1, 1, 5); cfg(1, 2, 0); cfg(1, 3, 9);
    cfg(3, 9, 15);  // no-op: register 9 keeps its mask
    step(1, 5, 0, 0, '0, '0, "R2 join");
    chk(use_cnt[3*CW +: CW] == 1 && use_cnt[0 +: 3*CW] == 0, "R2 join pool3", int'(use_cnt), 1 << (3*CW));
    step(1, 9, 0, 0, '0, '0, "R2 R3 alloc");
    chk(use_cnt[0 +: CW] == 1 && use_cnt[CW +: CW] == 0, "R2 nop kept mask", int'(use_cnt[0 +: 2*CW]), 1);

    // R4 / R6: release, then release at zero
    step(0, 0, 1, 9, '0, '0, "R4 release");
    step(0, 0, 1, 9, '0, '0, "R6 underflow");
    chk(rel_err[0] == 1'b1, "R6 flag", int'(rel_err), 1);
    step(0, 0, 0, 0, '0, '0, "R6 flag clears");

    // R5: same-cycle alloc and release
    step(1, 9, 1, 9, '0, '0, "R5 net");
    chk(use_cnt[0 +: CW] == 0 && rel_err == 0, "R5 no change", int'(use_cnt[0 +: CW]), 0);

    // R11 / R9: three slots in pool 0 (cap 2)
    step(0, 0, 0, 0, 3'b111, {4'd9, 4'd9, 4'd9}, "R11 oversize");
    chk(q_too_big[0] == 1'b1, "R11 direct", int'(q_too_big), 1);
    step(1, 9, 0, 0, 3'b000, '0, "R3 fill");
    step(1, 9, 0, 0, 3'b001, {4'd0, 4'd0, 4'd9}, "R9 full");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      bit av = ($urandom_range(0, 9) < 4);
      bit rv = ($urandom_range(0, 9) < 5);
      step(av, int'($urandom_range(0, NA-1)), rv, int'($urandom_range(0, NA-1)),
           QN'($urandom_range(0, 7)), QN*AW'($urandom), "R3 R4 R5 random");
      if (i % 500 == 250) cfg(1, int'($urandom_range(0, NF-1)), int'($urandom_range(0, 6)));
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule